// File: doc/BRIEF.md
# First-Fault Vector Gather Load Engine

This block carries out a predicated gather load with first-fault semantics over a fixed-length vector register. With the default 256-bit vector, the register holds four 64-bit elements. A start pulse delivers a vector of base addresses, a governing predicate with one bit per vector byte, a 5-bit immediate and the current first-fault mask. The block then visits the elements one at a time, lowest index first. For each active element it issues one 32-bit read through a valid/ready request port and waits for a response that carries data and a fault flag. The loaded word is sign-extended into its 64-bit lane.

Only a fault on the first active element is fatal. In that case the block raises a trap and leaves its result and mask outputs untouched. A fault on any later element is suppressed instead. That element's mask group and every higher group are cleared, no further reads are issued, and the affected lanes become zero. Lanes at or above the first mask element that is already clear are also written as zero. When the walk ends, the final result vector and mask appear on the outputs together with a one-cycle completion pulse.

Top module: `ffgather_engine`

## Requirements
- R1: A loaded 32-bit word is written into its 64-bit lane sign-extended, so bits 63..32 of the lane copy bit 31 of the word.
- R2: The read address for element e is the 64-bit base held in bits 64e+63..64e of `base_vec`, plus four times `imm5`. The sum is taken modulo 2^64, giving byte offsets 0 to 124.
- R3: Active elements are read in ascending index order, with exactly one request per element read.
- R4: Element e is active only when predicate bit 8e is 1. The other seven bits of its group have no effect. An inactive element issues no request and its lane is zero.
- R5: A fault returned for the first active element pulses `trap_o` instead of `done_o`. `result_o` and `ffr_o` keep their previous values.
- R6: A fault on a later active element e is suppressed. Lane e is zero, all 8 mask bits of groups e to the last element are cleared, lower groups keep their input values, and no request is issued for any higher element.
- R7: Once an element's mask bit (bit 8e of the working mask, whether clear on input or cleared by a fault) is 0, that lane and every higher lane are written as zero, even when their reads succeed.
- R8: With no active element the block issues no request, pulses `done_o`, outputs an all-zero result and returns `ffr_in` unchanged on `ffr_o`.
- R9: `done_o` lasts exactly one cycle, and the final `result_o` and `ffr_o` are valid in that same cycle. A `start` while `busy_o` is high is ignored.
- R10: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_addr` stays stable in the next cycle.
- R11: After reset, `done_o`, `trap_o`, `busy_o` and `req_valid` are low, and `result_o` and `ffr_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a gather when idle |
| base_vec | input | VLEN | Per-element 64-bit base addresses |
| pred | input | VLEN/8 | Governing predicate, one bit per byte |
| imm5 | input | 5 | Immediate, scaled by 4 into a byte offset |
| ffr_in | input | VLEN/8 | First-fault mask at start |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 64 | Byte address of the 32-bit read |
| rsp_valid | input | 1 | Response present |
| rsp_data | input | 32 | Read data |
| rsp_fault | input | 1 | Read faulted |
| result_o | output | VLEN | Committed result vector |
| ffr_o | output | VLEN/8 | Committed first-fault mask |
| done_o | output | 1 | One-cycle completion pulse |
| trap_o | output | 1 | One-cycle first-element fault pulse |
| busy_o | output | 1 | Walk in progress |

## Verification
The block's internal state becomes visible at the ports in three ways, each on a known timescale.

- **Walk index.** A corrupt index shows up at the very next request as a wrong `req_addr` or a missing request. It also shows up as a lane written in the wrong place, which can be seen at the next `done_o`.
- **Fault tracking and mask clearing.** A lost suppressed-fault flag produces an extra request within a cycle or two. A mis-cleared mask group shows up in `ffr_o` at the completion pulse of the same operation.
- **First-element tracking.** A wrong first-element flag turns a trap into a completion, or a completion into a trap, in the cycle after the faulting response. The previous result then either survives on `result_o` or is overwritten.

// File: rtl/ffg_pkg.sv
package ffg_pkg;
  localparam int unsigned ELEM_W = 64;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned GRP_W  = ELEM_W / 8;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_WAIT} ffg_state_e;

  // base plus the immediate scaled to a word-sized byte offset, wraps mod 2^64
  function automatic logic [ELEM_W-1:0] elem_addr(input logic [ELEM_W-1:0] base,
                                                  input logic [4:0] imm);
    return base + {{(ELEM_W-7){1'b0}}, imm, 2'b00};
  endfunction

  function automatic logic [ELEM_W-1:0] sext_word(input logic [WORD_W-1:0] w);
    return {{(ELEM_W-WORD_W){w[WORD_W-1]}}, w};
  endfunction
endpackage

// File: rtl/ffg_addr_gen.sv
module ffg_addr_gen
  import ffg_pkg::*;
#(
  parameter int unsigned VLEN  = 256,
  parameter int unsigned ELEMS = VLEN / ELEM_W,
  parameter int unsigned IDX_W = 2
) (
  input  logic [VLEN-1:0]   base_vec,
  input  logic [VLEN/8-1:0] pred,
  input  logic [4:0]        imm5,
  input  logic [IDX_W-1:0]  idx,
  output logic [ELEM_W-1:0] addr,
  output logic              active
);
  logic [ELEM_W-1:0] base_sel;

  always_comb begin
    base_sel = base_vec[int'(idx)*ELEM_W +: ELEM_W];
    addr     = elem_addr(base_sel, imm5);
    active   = pred[int'(idx)*GRP_W];
  end
endmodule

// File: rtl/ffg_ffr_track.sv
module ffg_ffr_track
  import ffg_pkg::*;
#(
  parameter int unsigned PRED_W = 32,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PRED_W-1:0] ffr_in,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic              commit,
  output logic              elem_live,
  output logic [PRED_W-1:0] ffr_o
);
  logic [PRED_W-1:0] work_q, work_d;

  always_comb begin
    work_d = work_q;
    if (load)        work_d = ffr_in;
    else if (clr_en) work_d[int'(idx)*GRP_W +: GRP_W] = '0;
  end

  assign elem_live = work_q[int'(idx)*GRP_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      ffr_o  <= '0;
    end else begin
      work_q <= work_d;
      if (commit) ffr_o <= work_d;
    end
  end

  // mask bits only ever fall during a walk
  AST_FFR_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ((work_q & ~$past(work_q)) == '0)); // R6
endmodule

// File: rtl/ffg_lane_store.sv
module ffg_lane_store
  import ffg_pkg::*;
#(
  parameter int unsigned VLEN  = 256,
  parameter int unsigned IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic              wr_zero,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] word,
  input  logic              commit,
  output logic [VLEN-1:0]   result_o
);
  logic [VLEN-1:0] work_q, work_d;

  always_comb begin
    work_d = work_q;
    if (clear) work_d = '0;
    else if (wr_en)
      work_d[int'(idx)*ELEM_W +: ELEM_W] = wr_zero ? '0 : sext_word(word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q   <= '0;
      result_o <= '0;
    end else begin
      work_q <= work_d;
      if (commit) result_o <= work_d;
    end
  end

  AST_LANE_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_zero && !clear) |=>
      (work_q[int'($past(idx))*ELEM_W + WORD_W +: (ELEM_W-WORD_W)]
        == {(ELEM_W-WORD_W){$past(word[WORD_W-1])}})); // R1
endmodule

// File: rtl/ffgather_engine.sv
module ffgather_engine
  import ffg_pkg::*;
#(
  parameter int unsigned VLEN = 256,
  localparam int unsigned PRED_W = VLEN / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VLEN-1:0]   base_vec,
  input  logic [PRED_W-1:0] pred,
  input  logic [4:0]        imm5,
  input  logic [PRED_W-1:0] ffr_in,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [63:0]       req_addr,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_data,
  input  logic              rsp_fault,
  output logic [VLEN-1:0]   result_o,
  output logic [PRED_W-1:0] ffr_o,
  output logic              done_o,
  output logic              trap_o,
  output logic              busy_o
);
  localparam int unsigned ELEMS = VLEN / ELEM_W;
  localparam int unsigned IDX_W = (ELEMS > 1) ? $clog2(ELEMS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ELEMS - 1);

  ffg_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [VLEN-1:0]   lat_base;
  logic [PRED_W-1:0] lat_pred;
  logic [4:0]        lat_imm;
  logic              first_pend_q, faulted_q, unknown_q;
  logic              done_q, trap_q;

  logic [ELEM_W-1:0] cur_addr;
  logic              cur_active, elem_live;

  // named internal events
  logic start_acc, in_scan, in_wait, issue_need, req_fire, skip_evt;
  logic rsp_take, trap_evt, sup_evt, good_evt, elem_end, last_elem, finish;
  logic uk_now, clr_en, wr_zero;

  assign start_acc  = (state_q == ST_IDLE) && start;
  assign in_scan    = (state_q == ST_SCAN);
  assign in_wait    = (state_q == ST_WAIT);
  assign issue_need = in_scan && cur_active && !faulted_q;
  assign req_fire   = issue_need && req_ready;
  assign skip_evt   = in_scan && !issue_need;
  assign rsp_take   = in_wait && rsp_valid;
  assign trap_evt   = rsp_take && rsp_fault && first_pend_q;
  assign sup_evt    = rsp_take && rsp_fault && !first_pend_q;
  assign good_evt   = rsp_take && !rsp_fault;
  assign elem_end   = skip_evt || sup_evt || good_evt;
  assign last_elem  = (idx_q == LAST_IDX);
  assign finish     = elem_end && last_elem;
  assign uk_now     = unknown_q || !elem_live;
  assign clr_en     = (skip_evt && faulted_q) || sup_evt;
  assign wr_zero    = skip_evt || sup_evt || (good_evt && uk_now);

  assign req_valid = issue_need;
  assign req_addr  = cur_addr;
  assign done_o    = done_q;
  assign trap_o    = trap_q;
  assign busy_o    = (state_q != ST_IDLE);

  ffg_addr_gen #(.VLEN(VLEN), .ELEMS(ELEMS), .IDX_W(IDX_W)) u_addr (
    .base_vec(lat_base), .pred(lat_pred), .imm5(lat_imm), .idx(idx_q),
    .addr(cur_addr), .active(cur_active)
  );

  ffg_ffr_track #(.PRED_W(PRED_W), .IDX_W(IDX_W)) u_ffr (
    .clk(clk), .rst_n(rst_n), .load(start_acc), .ffr_in(ffr_in),
    .clr_en(clr_en), .idx(idx_q), .commit(finish),
    .elem_live(elem_live), .ffr_o(ffr_o)
  );

  ffg_lane_store #(.VLEN(VLEN), .IDX_W(IDX_W)) u_lane (
    .clk(clk), .rst_n(rst_n), .clear(start_acc), .wr_en(elem_end),
    .wr_zero(wr_zero), .idx(idx_q), .word(rsp_data), .commit(finish),
    .result_o(result_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      idx_q        <= '0;
      lat_base     <= '0;
      lat_pred     <= '0;
      lat_imm      <= '0;
      first_pend_q <= 1'b0;
      faulted_q    <= 1'b0;
      unknown_q    <= 1'b0;
      done_q       <= 1'b0;
      trap_q       <= 1'b0;
    end else begin
      done_q <= finish;
      trap_q <= trap_evt;
      if (start_acc) begin
        lat_base     <= base_vec;
        lat_pred     <= pred;
        lat_imm      <= imm5;
        idx_q        <= '0;
        first_pend_q <= 1'b1;
        faulted_q    <= 1'b0;
        unknown_q    <= 1'b0;
        state_q      <= ST_SCAN;
      end else if (req_fire) begin
        state_q <= ST_WAIT;
      end else if (trap_evt) begin
        state_q <= ST_IDLE;
      end else if (elem_end) begin
        unknown_q <= uk_now || sup_evt;
        if (sup_evt)  faulted_q    <= 1'b1;
        if (good_evt) first_pend_q <= 1'b0;
        if (last_elem) begin
          state_q <= ST_IDLE;
        end else begin
          idx_q   <= idx_q + 1'b1;
          state_q <= ST_SCAN;
        end
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr))); // R10
  AST_REQ_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> cur_active); // R4
  AST_NO_REQ_AFTER_SUP: assert property (@(posedge clk) disable iff (!rst_n)
    faulted_q |-> !req_valid); // R6
  AST_TRAP_FIRST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (!done_o && $past(first_pend_q))); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
endmodule

// File: tb/sim_ffgather_engine.sv
module sim_ffgather_engine;
  localparam int VLEN = 256;
  localparam int NE   = VLEN / 64;
  localparam int PW   = VLEN / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [VLEN-1:0] base_vec = '0;
  logic [PW-1:0] pred = '0, ffr_in = '0;
  logic [4:0] imm5 = '0;
  logic req_valid, req_ready, rsp_valid, rsp_fault;
  logic [63:0] req_addr;
  logic [31:0] rsp_data;
  logic [VLEN-1:0] result_o;
  logic [PW-1:0] ffr_o;
  logic done_o, trap_o, busy_o;

  always #2.5 clk = ~clk;

  ffgather_engine #(.VLEN(VLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_vec(base_vec), .pred(pred),
    .imm5(imm5), .ffr_in(ffr_in), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_fault(rsp_fault), .result_o(result_o), .ffr_o(ffr_o), .done_o(done_o),
    .trap_o(trap_o), .busy_o(busy_o)
  );

  int checks = 0, errors = 0;
  int ops_seen = 0, ops_sent = 0, req_cnt = 0;

  logic [VLEN-1:0] exp_res_q[$];
  logic [PW-1:0]   exp_ffr_q[$];
  bit              exp_trap_q[$];
  int              exp_nreq_q[$];
  string           tag_q[$];
  logic [63:0]     addr_q[$];
  logic [VLEN-1:0] prev_res = '0;
  logic [PW-1:0]   prev_ffr = '0;

  function automatic logic [31:0] mem_word(input logic [63:0] a);
    return a[31:0] ^ {a[15:0], a[31:16]} ^ 32'h8000_1234;
  endfunction
  function automatic bit mem_fault(input logic [63:0] a);
    return a[47:40] == 8'hBD;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory responder: one outstanding read, variable latency and ready stalls
  initial begin
    bit hs, pend;
    logic [63:0] ha, pa;
    logic [3:0] lfsr;
    int cnt;
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0; rsp_fault = 1'b0;
    pend = 0; cnt = 0; lfsr = 4'b1011; pa = '0;
    forever begin
      @(posedge clk);
      hs = req_valid && req_ready;
      ha = req_addr;
      @(negedge clk);
      rsp_valid = 1'b0; rsp_fault = 1'b0;
      if (hs) begin
        req_cnt++;
        if (addr_q.size() == 0)
          check(0, "R4", "request with none expected", VLEN'(ha), '0);
        else begin
          logic [63:0] ea;
          ea = addr_q.pop_front();
          check(ha == ea, "R2", "request address/order (R3)", VLEN'(ha), VLEN'(ea));
        end
        pend = 1; pa = ha; cnt = int'(lfsr[2:1]);
      end
      if (pend) begin
        if (cnt == 0) begin
          rsp_valid = 1'b1; rsp_data = mem_word(pa); rsp_fault = mem_fault(pa);
          pend = 0;
        end else cnt--;
      end
      lfsr = {lfsr[2:0], lfsr[3] ^ lfsr[2]};
      req_ready = lfsr[0] | lfsr[3];
    end
  end

  // monitor: pops the scoreboard at each completion or trap
  initial begin
    bit prev_done = 0;
    forever begin
      @(negedge clk);
      if (done_o && prev_done) check(0, "R9", "done longer than one cycle", 1, 0);
      if (done_o || trap_o) begin
        ops_seen++;
        if (exp_res_q.size() == 0) check(0, "R9", "unexpected completion", 1, 0);
        else begin
          logic [VLEN-1:0] er; logic [PW-1:0] ef; bit et; int en; string tg;
          er = exp_res_q.pop_front(); ef = exp_ffr_q.pop_front();
          et = exp_trap_q.pop_front(); en = exp_nreq_q.pop_front(); tg = tag_q.pop_front();
          check(trap_o == et && done_o == !et, tg, "trap/done kind",
                VLEN'({trap_o, done_o}), VLEN'({et, !et}));
          check(result_o == er, tg, "result vector", result_o, er);
          check(ffr_o == ef, tg, "ffr", VLEN'(ffr_o), VLEN'(ef));
          check(req_cnt == en, tg, "request count", VLEN'(req_cnt), VLEN'(en));
        end
      end
      prev_done = done_o;
    end
  end

  // driver: computes the expectation, pushes it, then launches the operation
  task automatic run_op(input logic [VLEN-1:0] b, input logic [PW-1:0] p,
                        input logic [4:0] im, input logic [PW-1:0] f,
                        input string tg, input bit poke);
    logic [VLEN-1:0] res; logic [PW-1:0] fw; bit trap, sup, first, unk; int nreq;
    res = '0; fw = f; trap = 0; sup = 0; first = 1; unk = 0; nreq = 0;
    for (int e = 0; e < NE; e++) begin
      bit act, okload; logic [63:0] a; logic [31:0] w;
      act = p[e*8]; okload = 0; w = '0;
      if (act && !sup) begin
        a = b[e*64 +: 64] + 64'(im) * 64'd4;
        addr_q.push_back(a); nreq++;
        if (mem_fault(a)) begin
          if (first) begin trap = 1; break; end
          sup = 1;
        end else begin
          w = mem_word(a); first = 0; okload = 1;
        end
      end
      if (sup) fw[e*8 +: 8] = 8'h00;
      if (fw[e*8] == 1'b0) unk = 1;
      if (okload && !unk) res[e*64 +: 64] = 64'(signed'(w));
    end
    if (trap) begin res = prev_res; fw = prev_ffr; end
    prev_res = res; prev_ffr = fw;
    exp_res_q.push_back(res); exp_ffr_q.push_back(fw); exp_trap_q.push_back(trap);
    exp_nreq_q.push_back(nreq); tag_q.push_back(tg);
    ops_sent++;
    @(negedge clk);
    req_cnt = 0;
    base_vec = b; pred = p; imm5 = im; ffr_in = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      base_vec = ~b; pred = '1; imm5 = 5'd7; ffr_in = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (ops_seen < ops_sent) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(!done_o && !trap_o && !busy_o && !req_valid, "R11", "control outputs after reset",
          VLEN'({done_o, trap_o, busy_o, req_valid}), '0);
    check(result_o == '0 && ffr_o == '0, "R11", "data outputs after reset", result_o, '0);

    // R1/R3: all active, mixed sign words, no faults
    run_op({64'hFFFF_0000_8000_0000, 64'h0000_0000_0000_3000,
            64'h0000_0000_2000_0010, 64'h0000_0000_0000_1000},
           32'h0101_0101, 5'd0, '1, "R1", 0);
    // R2: largest offset with 64-bit wrap, elements 0 and 2 active (R4 lanes 1,3 zero)
    run_op({64'h0000_0000_0000_4444, 64'h0000_0012_3456_7000,
            64'h0000_0000_0000_5550, 64'hFFFF_FFFF_FFFF_FFF0},
           32'h0001_0001, 5'd31, '1, "R2", 0);
    // R4: only bit 8 set as a low group bit; other group bits high
    run_op({64'h0000_0000_0000_0040, 64'h0000_0000_0000_0030,
            64'h0000_0000_0000_7720, 64'h0000_0000_0000_0010},
           32'hFEFE_01FE, 5'd3, '1, "R4", 0);
    // R8: no active element at all
    run_op({4{64'h0000_BD00_0000_0000}}, 32'hFEFE_FEFE, 5'd1, 32'h5A5A_A5A5, "R8", 0);
    // R5: first active element (index 1) faults; outputs keep previous values
    run_op({64'h0000_0000_0000_0300, 64'h0000_0000_0000_0200,
            64'h0000_BD00_0000_0100, 64'h0000_BD00_0000_0000},
           32'h0101_0100, 5'd2, '1, "R5", 0);
    // R6: element 2 faults after a good element 0 and 1; groups 2,3 cleared
    run_op({64'h0000_0000_0000_9000, 64'h0000_BD00_0000_8000,
            64'h0000_0000_8765_4320, 64'h0000_0000_0ABC_0000},
           32'h0101_0101, 5'd5, 32'hFFFF_FF7F, "R6", 0);
    // R6: fault on the last element only
    run_op({64'h0000_BD00_0000_0C00, 64'h0000_0000_0000_0B00,
            64'h0000_0000_0000_0A00, 64'h0000_0000_F000_0900},
           32'h0101_0101, 5'd0, '1, "R6", 0);
    // R7: group 1 already clear on input; lanes 1..3 zero though reads succeed
    run_op({64'h0000_0000_0000_0D30, 64'h0000_0000_0000_0D20,
            64'h0000_0000_8000_0D10, 64'h0000_0000_0000_0D00},
           32'h0101_0101, 5'd9, 32'hFFFF_00FF, "R7", 0);
    // R9: start while busy is ignored
    run_op({64'h0000_0000_1111_0000, 64'h0000_0000_2222_0000,
            64'h0000_0000_3333_0000, 64'h0000_0000_4444_0000},
           32'h0101_0101, 5'd4, '1, "R9", 1);
    repeat (20) @(negedge clk);
    check(ops_seen == ops_sent && exp_res_q.size() == 0, "R9", "completions vs launches",
          VLEN'(ops_seen), VLEN'(ops_sent));
    check(addr_q.size() == 0, "R3", "unissued expected requests",
          VLEN'(addr_q.size()), '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", ops_seen, ops_sent);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule